// File: doc/BRIEF.md
# Byte-Copy Engine with Shared-Adder Address Stepping

This block moves a run of bytes from one region of memory to another while the processor does other work. Software programs a source pointer, a destination pointer, a step for each pointer and a byte count. It then sets a start bit. The engine copies each byte in two bus cycles. In the first cycle it reads from the source pointer and latches the byte. In the second cycle it writes the latched byte to the destination pointer. A count register falls by one per byte, and the job ends when the count reaches zero.

Both pointers advance through one shared adder. Its first operand is always the pointer that is on the bus in that cycle, so a pointer moves in the same cycle it is used. Each pointer has an 8-bit step, a carry-in bit and a sign-fill bit. The sign-fill bit drives every step bit above bit 7 high. These controls give forward steps, 256-byte page steps and backward steps without a subtractor. A hold bit freezes a pointer, which suits filling memory from one address or writing repeatedly to one I/O address.

The processor reaches the registers through an 8-bit select/strobe port, and every configuration register can be read back. The memory side is a plain master: address, write data, read data, and read and write strobes. Read data must be valid in the same cycle as the read strobe.

Top module: `blit_engine`

## Requirements
- R1: After reset the engine is idle. `busy`, `xfer_end`, `mem_rd` and `mem_wr` are low, and every readable register returns 0.
- R2: Each pointer is written one byte lane at a time and reads back the same way. Source lanes are at selects 0..2 and destination lanes at 3..5, with lane 0 holding bits 7:0. Only bits 3:0 of lane 2 exist. The steps are at selects 6 (source) and 7 (destination), and both read back.
- R3: Writing 1 to bit 0 of select 12 with a non-zero count starts a job. Each byte takes one cycle with `mem_rd` high and the source pointer on `mem_addr`. The next cycle has `mem_wr` high, the destination pointer on `mem_addr`, and the byte read in the previous cycle on `mem_wdata`.
- R4: After each access, the pointer used becomes pointer + step_ext + carry, modulo 2^20. step_ext is the 8-bit step with bits 19:8 taken from the sign-fill bit. The control registers are at select 8 (source) and 9 (destination), with bit 0 = carry-in, bit 1 = sign-fill and bit 2 = hold.
- R5: With carry-in set and a step of 0xFF, the pointer advances by 256 per access.
- R6: Two settings move the pointer back by 1 per access: carry-in set with step 0xFE and sign-fill set, or carry-in clear with step 0xFF and sign-fill set.
- R7: With the hold bit set, that pointer stays unchanged across every access.
- R8: The count is at selects 10 (low) and 11 (high) and falls by one per byte. A job of N bytes spends 2N cycles accessing memory. It then spends one cycle with `xfer_end` high, reads back a count of 0, and sets status bit 1 (done). The done bit stays set until the next accepted start.
- R9: A start request while the count is 0 is ignored. The engine stays idle and issues no strobes.
- R10: While `busy` is high (from the first access cycle through the end cycle), the engine ignores processor writes to the pointers, steps, controls, count and start bit. Select 12 reads back bit 0 = busy and bit 1 = done.
- R11: Pointer arithmetic wraps, so stepping forward past 0xFFFFF continues at 0x00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 4 | Register select |
| cpu_wdata | input | 8 | Register write data |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_rdata | output | 8 | Register read data (0 when `cpu_rd` is low) |
| mem_addr | output | 20 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the read cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| busy | output | 1 | Job in progress |
| xfer_end | output | 1 | One-cycle end-of-job indication |

## Verification
The bench uses the default parameters: a 20-bit address, 8-bit steps and a 16-bit count. With the 20-bit address, the wrap from 0xFFFFF to 0 can be reached within a four-byte job, and the partial upper lane shows its masking on readback. With the 16-bit count, jobs of one byte and of several bytes are both short. Each row of the vector table sets one step mode: plain copy, page step, both backward forms, hold-source fill, hold-destination port write, and wrap. Directed tests then cover the reset state, a start with a zero count, and writes issued while the engine is busy.

// File: rtl/blit_pkg.sv
package blit_pkg;
    localparam int SEL_W       = 4;
    localparam int SEL_SRC_A0  = 0;
    localparam int SEL_DST_A0  = 3;
    localparam int SEL_SRC_INC = 6;
    localparam int SEL_DST_INC = 7;
    localparam int SEL_SRC_CTL = 8;
    localparam int SEL_DST_CTL = 9;
    localparam int SEL_CNT0    = 10;
    localparam int SEL_CMD     = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } blit_state_e;

    // bit 0 carry-in, bit 1 sign-fill of upper step bits, bit 2 hold
    typedef struct packed {
        logic hold;
        logic fill;
        logic cin;
    } step_ctl_t;
endpackage

// File: rtl/blit_addr_chan.sv
module blit_addr_chan
    import blit_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int INC_W   = 8,
    parameter int DATA_W  = 8,
    parameter int A_BASE  = 0,
    parameter int INC_SEL = 6,
    parameter int CTL_SEL = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_addr,
    output logic [ADDR_W-1:0] addr,
    output logic [INC_W-1:0]  inc,
    output step_ctl_t         ctl
);
    localparam int LANES = (ADDR_W + DATA_W - 1) / DATA_W;
    localparam int PAD_W = LANES * DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [INC_W-1:0]  inc;
        step_ctl_t         ctl;
    } chan_t;

    chan_t             r_d, r_q;
    logic [PAD_W-1:0]  pad_d;

    always_comb begin
        r_d   = r_q;
        pad_d = PAD_W'(r_q.addr);
        if (upd_en) begin
            r_d.addr = upd_addr;
        end else if (cfg_we) begin
            for (int l = 0; l < LANES; l++) begin
                if (cfg_sel == SEL_W'(A_BASE + l))
                    pad_d[l*DATA_W +: DATA_W] = cfg_wdata;
            end
            r_d.addr = pad_d[ADDR_W-1:0];
            if (cfg_sel == SEL_W'(INC_SEL))
                r_d.inc = INC_W'(cfg_wdata);
            if (cfg_sel == SEL_W'(CTL_SEL))
                r_d.ctl = step_ctl_t'(cfg_wdata[2:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign addr = r_q.addr;
    assign inc  = r_q.inc;
    assign ctl  = r_q.ctl;

    // R7
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && r_q.ctl.hold) |=> $stable(r_q.addr));
endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen
    import blit_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int INC_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              acc_en,
    input  logic              acc_dst,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [INC_W-1:0]  src_inc,
    output logic [INC_W-1:0]  dst_inc,
    output step_ctl_t         src_ctl,
    output step_ctl_t         dst_ctl
);
    localparam int NCH   = 2;
    localparam int UPR_W = ADDR_W - INC_W;

    logic [ADDR_W-1:0] ch_addr [NCH];
    logic [INC_W-1:0]  ch_inc  [NCH];
    step_ctl_t         ch_ctl  [NCH];

    logic [ADDR_W-1:0] op_a, step_ext, sum;
    logic [INC_W-1:0]  sel_inc;
    step_ctl_t         sel_ctl;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        blit_addr_chan #(
            .ADDR_W (ADDR_W),
            .INC_W  (INC_W),
            .DATA_W (DATA_W),
            .A_BASE ((c == 0) ? SEL_SRC_A0  : SEL_DST_A0),
            .INC_SEL((c == 0) ? SEL_SRC_INC : SEL_DST_INC),
            .CTL_SEL((c == 0) ? SEL_SRC_CTL : SEL_DST_CTL)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we),
            .cfg_sel  (cfg_sel),
            .cfg_wdata(cfg_wdata),
            .upd_en   (acc_en && (acc_dst == (c == 1))),
            .upd_addr (sum),
            .addr     (ch_addr[c]),
            .inc      (ch_inc[c]),
            .ctl      (ch_ctl[c])
        );
    end

    // one adder: operand A is whatever pointer is on the bus this cycle
    always_comb begin
        op_a     = acc_dst ? ch_addr[1] : ch_addr[0];
        sel_inc  = acc_dst ? ch_inc[1]  : ch_inc[0];
        sel_ctl  = acc_dst ? ch_ctl[1]  : ch_ctl[0];
        step_ext = sel_ctl.hold ? '0 : {{UPR_W{sel_ctl.fill}}, sel_inc};
        sum      = op_a + step_ext
                 + {{(ADDR_W-1){1'b0}}, sel_ctl.cin & ~sel_ctl.hold};
    end

    assign bus_addr = op_a;
    assign src_addr = ch_addr[0];
    assign dst_addr = ch_addr[1];
    assign src_inc  = ch_inc[0];
    assign dst_inc  = ch_inc[1];
    assign src_ctl  = ch_ctl[0];
    assign dst_ctl  = ch_ctl[1];
endmodule

// File: rtl/blit_count.sv
module blit_count
    import blit_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              dec,
    output logic [CNT_W-1:0]  count,
    output logic              cnt_zero,
    output logic              cnt_last
);
    localparam int LANES = CNT_W / DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_reg_t;

    cnt_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (dec) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end else if (cfg_we) begin
            for (int l = 0; l < LANES; l++) begin
                if (cfg_sel == SEL_W'(SEL_CNT0 + l))
                    r_d.cnt[l*DATA_W +: DATA_W] = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign count    = r_q.cnt;
    assign cnt_zero = (r_q.cnt == '0);
    assign cnt_last = (r_q.cnt == CNT_W'(1));

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !cnt_zero);
endmodule

// File: rtl/blit_ctrl.sv
module blit_ctrl
    import blit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              cnt_zero,
    input  logic              cnt_last,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              cnt_dec,
    output logic              busy,
    output logic              xfer_end,
    output logic              done_flag,
    output logic [DATA_W-1:0] xfer_data
);
    typedef struct packed {
        blit_state_e       st;
        logic [DATA_W-1:0] xfer;
        logic              done;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        cnt_dec = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_req && !cnt_zero) begin
                    r_d.st   = ST_READ;
                    r_d.done = 1'b0;
                end
            end
            ST_READ: begin
                r_d.xfer = mem_rdata;
                r_d.st   = ST_WRITE;
            end
            ST_WRITE: begin
                cnt_dec = 1'b1;
                if (cnt_last) begin
                    r_d.st   = ST_DONE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.st = ST_READ;
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, xfer: '0, done: 1'b0};
        else        r_q <= r_d;
    end

    assign mem_rd    = (r_q.st == ST_READ);
    assign mem_wr    = (r_q.st == ST_WRITE);
    assign busy      = (r_q.st != ST_IDLE);
    assign xfer_end  = (r_q.st == ST_DONE);
    assign done_flag = r_q.done;
    assign xfer_data = r_q.xfer;

    // R3
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_READ) |=> (r_q.st == ST_WRITE));
    // R8
    last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WRITE && cnt_last) |=> (r_q.st == ST_DONE));
    // R9
    zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && cnt_zero) |=> (r_q.st == ST_IDLE));
endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int INC_W  = 8,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  cpu_sel,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              busy,
    output logic              xfer_end
);
    localparam int A_LANES = (ADDR_W + DATA_W - 1) / DATA_W;
    localparam int A_PAD_W = A_LANES * DATA_W;
    localparam int C_LANES = CNT_W / DATA_W;

    logic              cfg_we, start_req, cnt_dec, cnt_zero, cnt_last, done_flag;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [INC_W-1:0]  src_inc, dst_inc;
    step_ctl_t         src_ctl, dst_ctl;
    logic [CNT_W-1:0]  count;
    logic [A_PAD_W-1:0] src_pad, dst_pad;
    logic [DATA_W-1:0] rd_mux;

    assign cfg_we    = cpu_wr && !busy;
    assign start_req = cpu_wr && (cpu_sel == SEL_W'(SEL_CMD)) && cpu_wdata[0];

    blit_addr_gen #(.ADDR_W(ADDR_W), .INC_W(INC_W), .DATA_W(DATA_W)) u_agen (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cpu_sel),
        .cfg_wdata(cpu_wdata),
        .acc_en   (mem_rd | mem_wr),
        .acc_dst  (mem_wr),
        .bus_addr (mem_addr),
        .src_addr (src_addr),
        .dst_addr (dst_addr),
        .src_inc  (src_inc),
        .dst_inc  (dst_inc),
        .src_ctl  (src_ctl),
        .dst_ctl  (dst_ctl)
    );

    blit_count #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cpu_sel),
        .cfg_wdata(cpu_wdata),
        .dec      (cnt_dec),
        .count    (count),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last)
    );

    blit_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_req(start_req),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last),
        .mem_rdata(mem_rdata),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .cnt_dec  (cnt_dec),
        .busy     (busy),
        .xfer_end (xfer_end),
        .done_flag(done_flag),
        .xfer_data(mem_wdata)
    );

    always_comb begin
        src_pad = A_PAD_W'(src_addr);
        dst_pad = A_PAD_W'(dst_addr);
        rd_mux  = '0;
        for (int l = 0; l < A_LANES; l++) begin
            if (cpu_sel == SEL_W'(SEL_SRC_A0 + l)) rd_mux = src_pad[l*DATA_W +: DATA_W];
            if (cpu_sel == SEL_W'(SEL_DST_A0 + l)) rd_mux = dst_pad[l*DATA_W +: DATA_W];
        end
        for (int l = 0; l < C_LANES; l++) begin
            if (cpu_sel == SEL_W'(SEL_CNT0 + l)) rd_mux = count[l*DATA_W +: DATA_W];
        end
        if (cpu_sel == SEL_W'(SEL_SRC_INC)) rd_mux = DATA_W'(src_inc);
        if (cpu_sel == SEL_W'(SEL_DST_INC)) rd_mux = DATA_W'(dst_inc);
        if (cpu_sel == SEL_W'(SEL_SRC_CTL)) rd_mux = DATA_W'(src_ctl);
        if (cpu_sel == SEL_W'(SEL_DST_CTL)) rd_mux = DATA_W'(dst_ctl);
        if (cpu_sel == SEL_W'(SEL_CMD))     rd_mux = DATA_W'({done_flag, busy});
    end

    assign cpu_rdata = cpu_rd ? rd_mux : '0;

    // R3
    wdata_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == $past(mem_rdata)));
    // R10
    busy_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_wr) |=> ($stable(src_inc) && $stable(dst_inc)
                              && $stable(src_ctl) && $stable(dst_ctl)));
endmodule

// File: tb/blit_engine_tb.sv
module blit_engine_tb;
    import blit_pkg::*;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic [19:0] ld_base;
        logic [7:0]  ld_inc;
        logic [2:0]  ld_ctl;
        logic [19:0] st_base;
        logic [7:0]  st_inc;
        logic [2:0]  st_ctl;
        logic [15:0] cnt;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{20'h01000, 8'h01, 3'd0, 20'h02000, 8'h01, 3'd0, 16'd5},
        '{20'h00100, 8'hFF, 3'd1, 20'h00800, 8'h01, 3'd0, 16'd4},
        '{20'h00A10, 8'hFE, 3'd3, 20'h00300, 8'hFF, 3'd2, 16'd6},
        '{20'h00055, 8'h00, 3'd4, 20'h00600, 8'h01, 3'd0, 16'd4},
        '{20'hFFFFE, 8'h01, 3'd0, 20'h00C00, 8'h01, 3'd0, 16'd4},
        '{20'h00400, 8'h02, 3'd0, 20'h00E00, 8'h00, 3'd4, 16'd3},
        '{20'h00123, 8'h01, 3'd0, 20'h00456, 8'h01, 3'd0, 16'd1}
    };
    localparam string VTAG [NV] = '{"R3", "R5", "R6", "R7", "R11", "R7", "R8"};

    logic        clk = 0, rst_n = 0;
    logic [3:0]  cpu_sel = 0;
    logic [7:0]  cpu_wdata = 0, cpu_rdata, mem_wdata, mem_rdata;
    logic        cpu_wr = 0, cpu_rd = 0, mem_rd, mem_wr, busy, xfer_end;
    logic [19:0] mem_addr;

    logic [7:0]  mem [4096];
    logic [19:0] rd_log [64];
    logic [19:0] wr_log [64];
    logic [7:0]  wd_log [64];
    int          rd_n = 0, wr_n = 0, n_chk = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    blit_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy), .xfer_end(xfer_end)
    );

    assign mem_rdata = mem[mem_addr[11:0]];

    always @(posedge clk) if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;

    always @(negedge clk) begin
        if (mem_rd && rd_n < 64) begin rd_log[rd_n] = mem_addr; rd_n++; end
        if (mem_wr && wr_n < 64) begin wr_log[wr_n] = mem_addr; wd_log[wr_n] = mem_wdata; wr_n++; end
    end

    function automatic logic [7:0] pat(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
    endfunction

    function automatic logic [19:0] step(input logic [19:0] a, input logic [7:0] inc,
                                         input logic [2:0] ctl);
        if (ctl[2]) return a;
        return a + {{12{ctl[1]}}, inc} + {19'd0, ctl[0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_write(input int s, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = 4'(s); cpu_wdata = d; cpu_wr = 1;
        @(negedge clk);
        cpu_wr = 0;
    endtask

    task automatic cpu_read(input int s, output logic [7:0] d);
        @(negedge clk);
        cpu_sel = 4'(s); cpu_rd = 1;
        #1 d = cpu_rdata;
        cpu_rd = 0;
    endtask

    task automatic read_addr(input int base, output logic [19:0] a);
        logic [7:0] b0, b1, b2;
        cpu_read(base, b0); cpu_read(base + 1, b1); cpu_read(base + 2, b2);
        a = {b2[3:0], b1, b0};
    endtask

    task automatic prog(input vec_t v);
        for (int l = 0; l < 3; l++) begin
            cpu_write(SEL_SRC_A0 + l, 8'(v.ld_base >> (8*l)));
            cpu_write(SEL_DST_A0 + l, 8'(v.st_base >> (8*l)));
        end
        cpu_write(SEL_SRC_INC, v.ld_inc);
        cpu_write(SEL_DST_INC, v.st_inc);
        cpu_write(SEL_SRC_CTL, {5'd0, v.ld_ctl});
        cpu_write(SEL_DST_CTL, {5'd0, v.st_ctl});
        cpu_write(SEL_CNT0, v.cnt[7:0]);
        cpu_write(SEL_CNT0 + 1, v.cnt[15:8]);
    endtask

    task automatic wait_end(output int cyc);
        cyc = 0;
        while (!xfer_end && cyc < 2000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [19:0] a;
        int          cyc;

        for (int i = 0; i < 4096; i++) mem[i] = pat(12'(i));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check(!busy && !xfer_end && !mem_rd && !mem_wr, "R1", "idle outputs",
              {busy, xfer_end, mem_rd, mem_wr}, 0);
        cpu_read(SEL_SRC_A0, d);  check(d == 0, "R1", "src lane0", d, 0);
        cpu_read(SEL_DST_INC, d); check(d == 0, "R1", "dst step", d, 0);
        cpu_read(SEL_CNT0, d);    check(d == 0, "R1", "count lo", d, 0);
        cpu_read(SEL_CMD, d);     check(d == 0, "R1", "status", d, 0);

        // R2 lane masking and step readback
        cpu_write(SEL_SRC_A0 + 2, 8'hFF);
        cpu_read(SEL_SRC_A0 + 2, d); check(d == 8'h0F, "R2", "upper lane", d, 8'h0F);
        cpu_write(SEL_DST_INC, 8'hA5);
        cpu_read(SEL_DST_INC, d);    check(d == 8'hA5, "R2", "dst step", d, 8'hA5);

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic [19:0] ea, eb;
            bit          ok_r, ok_w, ok_d;
            for (int i = 0; i < 4096; i++) mem[i] = pat(12'(i));
            prog(VECS[v]);
            rd_n = 0; wr_n = 0;
            cpu_write(SEL_CMD, 8'h01);
            wait_end(cyc);
            check(cyc == 2 * int'(VECS[v].cnt), "R8", "access cycles", cyc, 2 * VECS[v].cnt);
            check(rd_n == int'(VECS[v].cnt) && wr_n == int'(VECS[v].cnt), "R3", "access counts",
                  {rd_n[15:0], wr_n[15:0]}, {VECS[v].cnt, VECS[v].cnt});
            ea = VECS[v].ld_base; eb = VECS[v].st_base;
            ok_r = 1; ok_w = 1; ok_d = 1;
            for (int k = 0; k < int'(VECS[v].cnt); k++) begin
                if (rd_log[k] != ea) ok_r = 0;
                if (wr_log[k] != eb) ok_w = 0;
                if (wd_log[k] != pat(ea[11:0])) ok_d = 0;
                ea = step(ea, VECS[v].ld_inc, VECS[v].ld_ctl);
                eb = step(eb, VECS[v].st_inc, VECS[v].st_ctl);
            end
            check(ok_r, VTAG[v], "R4 source sequence", rd_log[0], VECS[v].ld_base);
            check(ok_w, VTAG[v], "R4 dest sequence", wr_log[0], VECS[v].st_base);
            check(ok_d, "R3", "write data", wd_log[0], pat(VECS[v].ld_base[11:0]));
            read_addr(SEL_SRC_A0, a); check(a == ea, VTAG[v], "final source ptr", a, ea);
            read_addr(SEL_DST_A0, a); check(a == eb, VTAG[v], "final dest ptr", a, eb);
        end

        // R9 start with zero count
        cpu_write(SEL_CNT0, 8'h00); cpu_write(SEL_CNT0 + 1, 8'h00);
        rd_n = 0; wr_n = 0;
        cpu_write(SEL_CMD, 8'h01);
        repeat (4) @(negedge clk);
        check(!busy && rd_n == 0 && wr_n == 0, "R9", "zero-count start", {busy, 8'(rd_n)}, 0);

        // R10 writes while busy ignored, R8 done flag
        prog('{20'h00200, 8'h01, 3'd0, 20'h00900, 8'h01, 3'd0, 16'd8});
        rd_n = 0; wr_n = 0;
        cpu_write(SEL_CMD, 8'h01);
        cpu_write(SEL_SRC_INC, 8'h77);
        cpu_write(SEL_CNT0, 8'h01);
        cpu_write(SEL_DST_CTL, 8'h04);
        cpu_write(SEL_CMD, 8'h01);
        wait_end(cyc);
        @(negedge clk);
        check(wr_n == 8, "R10", "count kept while busy", wr_n, 8);
        check(wr_log[7] == 20'h00907, "R10", "dest ctl kept while busy", wr_log[7], 20'h00907);
        cpu_read(SEL_SRC_INC, d); check(d == 8'h01, "R10", "step kept", d, 8'h01);
        cpu_read(SEL_CMD, d);     check(d == 8'h02, "R8", "done status", d, 8'h02);
        cpu_read(SEL_CNT0, d);    check(d == 8'h00, "R8", "count at end", d, 8'h00);
        cpu_write(SEL_CNT0, 8'h02);
        cpu_write(SEL_CMD, 8'h01);
        cpu_read(SEL_CMD, d);     check(d == 8'h01, "R8", "done cleared on start", d, 8'h01);
        wait_end(cyc);
        check(cyc < 2000, "R8", "second job ends", cyc, 0);
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule